// File: doc/BRIEF.md
# Hard-decision Viterbi decoder (rate 1/2, K=7)

This block recovers a data stream from a rate-1/2, constraint-length-7 convolutional code received as hard decisions. On each cycle that `in_valid` is high, it takes one pair of code bits. It computes a Hamming cost for every trellis branch and runs add-compare-select across all 64 states. Each state keeps an 8-bit path metric, and all metrics are renormalised every step. A register-exchange survivor history, 34 steps deep per state, supplies the decided bit.

Each accepted pair yields one decoded bit, 34 trellis steps behind the input, once the history is full. Decoding always starts from the all-zero encoder state after reset. The block sits behind a demodulator slicer and ahead of any framing logic.

Top module: `hd_viterbi`

## Requirements
- R1: The code uses a 7-bit window made of the new data bit at bit 6 and the 6-bit encoder state at bits 5..0, with bit 5 the most recent earlier bit. Code bit `in_bits[1]` is the parity of the window masked with octal 171, and `in_bits[0]` is the parity with octal 133. With an error-free stream, the decoded output equals the data.
- R2: Branch cost is the Hamming distance (0, 1 or 2) between the received pair and the branch's expected pair. Isolated single code-bit errors at least 40 pairs apart are corrected.
- R3: `out_valid` stays low until 34 pairs have been accepted after reset. It first rises in the cycle after the 34th accepted pair.
- R4: After warm-up, `out_valid` is high for exactly one cycle after each accepted pair and at no other time. The k-th valid output (counting from 0) is data bit k.
- R5: Cycles with `in_valid` low are ignored. `in_bits` has no effect on them, the path metrics are unchanged and no output is produced.
- R6: Path metrics are 8-bit unsigned and have the step minimum subtracted each step. No metric reaches 128, even under a stream of random noise.
- R7: Synchronous reset clears the output, sets state 0 to metric 0 and all other states to 64, and empties the history. A new stream after reset decodes correctly from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received pair present this cycle |
| in_bits | input | 2 | Received code bits: [1] for the 171 output, [0] for the 133 output |
| out_valid | output | 1 | Decoded bit present |
| out_bit | output | 1 | Decoded data bit |

## Verification
Every result is registered, so a decoded bit appears on the first clock edge after the pair that releases it. The bench drives inputs and samples outputs on falling edges, so each output is read half a cycle after that edge. The first valid output must coincide with an accepted-pair count of exactly 34. From then on, each valid output is matched to the next queued data bit, and the bench requires that the previous edge carried an accepted pair. At the end of each stream, the output count must equal the accepted count minus 33. This ties every bit to its 34-step decision latency even when idle gaps are inserted.

// File: rtl/hd_viterbi.sv
module hd_viterbi #(
  parameter int K     = 7,
  parameter int DEPTH = 34,
  parameter int MW    = 8,
  parameter logic [6:0] G0 = 7'o171,
  parameter logic [6:0] G1 = 7'o133
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_bits,
  output logic       out_valid,
  output logic       out_bit
);
  localparam int SW   = K - 1;
  localparam int NS   = 1 << SW;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam logic [MW-1:0] INIT = MW'(1 << (MW - 2));

  logic [NS-1:0][MW-1:0]    pm, npm;
  logic [NS-1:0][DEPTH-1:0] sv, nsv;
  logic [MW-1:0]            mn;
  logic [SW-1:0]            best;
  logic [CW-1:0]            cnt;

  function automatic logic [MW-1:0] bmet(input logic [K-1:0] w, input logic [1:0] r);
    logic e0, e1;
    e0 = (^(w & G0)) ^ r[1];
    e1 = (^(w & G1)) ^ r[0];
    return MW'(e0) + MW'(e1);
  endfunction

  always_comb begin
    logic [SW-1:0] p0, p1;
    logic          b;
    logic [MW-1:0] m0, m1;
    mn   = '1;
    best = '0;
    for (int i = 0; i < NS; i++) begin
      b  = (i >= NS / 2);
      p0 = SW'((i % (NS / 2)) * 2);
      p1 = p0 | SW'(1);
      m0 = pm[p0] + bmet({b, p0}, in_bits);
      m1 = pm[p1] + bmet({b, p1}, in_bits);
      if (m1 < m0) begin
        npm[i] = m1;
        nsv[i] = {sv[p1][DEPTH-2:0], b};
      end else begin
        npm[i] = m0;
        nsv[i] = {sv[p0][DEPTH-2:0], b};
      end
      if (npm[i] < mn) begin
        mn   = npm[i];
        best = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : INIT;
      sv        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid && (cnt >= CW'(DEPTH - 1));
      if (in_valid) begin
        for (int i = 0; i < NS; i++) pm[i] <= npm[i] - mn;
        sv      <= nsv;
        out_bit <= nsv[best][DEPTH-1];
        if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
      end
    end
  end

  logic any_big;
  always_comb begin
    any_big = 1'b0;
    for (int i = 0; i < NS; i++) any_big |= pm[i][MW-1];
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) !any_big);
  a_r3_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(cnt) >= CW'(DEPTH - 1));
  a_r4_valid_follows_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pm) && !out_valid);
  a_r7_reset_quiet: assert property (@(posedge clk) $past(rst) |-> !out_valid);
endmodule

// File: tb/hd_viterbi_bench.sv
module hd_viterbi_bench;
  localparam int DEPTH = 34;
  localparam int MAXN  = 1200;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] in_bits = 0;
  logic out_valid, out_bit;

  int checks = 0, fails = 0;
  int acc_cnt = 0, oidx = 0;
  bit acc_last = 0, chk_en = 0, done = 0;
  bit exp_d [MAXN];
  logic [5:0] st;

  hd_viterbi u_hd_viterbi (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_bits(in_bits), .out_valid(out_valid), .out_bit(out_bit));

  always #2.5 clk = ~clk;

  function automatic logic [1:0] enc(input bit b, input logic [5:0] s);
    logic [6:0] w;
    w = {b, s};
    return {^(w & 7'o171), ^(w & 7'o133)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      check(acc_last, "R4 valid without accept", 0, 1);
      if (oidx == 0) check(acc_cnt == DEPTH, "R3 first valid", acc_cnt, DEPTH);
      if (chk_en && oidx < MAXN)
        check(out_bit == exp_d[oidx], "R1/R2 decoded bit", out_bit, exp_d[oidx]);
      oidx++;
    end
  end

  task automatic step(input bit v, input logic [1:0] b);
    @(negedge clk);
    in_valid = v;
    in_bits  = b;
    @(posedge clk);
    acc_last = v;
    if (v) acc_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R7 reset output", out_valid, 0);
    rst = 0; acc_cnt = 0; oidx = 0; acc_last = 0; st = '0;
  endtask

  // mode 0 zeros, 1 ones, 2 random data, 3 random noise
  task automatic run(input int n, input int mode, input int err_gap, input bit gaps);
    logic [1:0] c;
    bit b;
    do_reset();
    chk_en = (mode != 3);
    for (int k = 0; k < n; k++) begin
      b = (mode == 1) ? 1'b1 : (mode == 0) ? 1'b0 : 1'($urandom);
      exp_d[k] = b;
      c = enc(b, st);
      st = {b, st[5:1]};
      if (mode == 3) c = 2'($urandom);
      if (err_gap > 0 && (k % err_gap) == err_gap / 2) c[$urandom % 2] ^= 1'b1;
      if (gaps && ($urandom % 4) == 0)
        for (int g = 0; g < 1 + int'($urandom % 3); g++) step(1'b0, 2'($urandom));
      step(1'b1, c);
    end
    step(1'b0, 2'($urandom));
    repeat (3) step(1'b0, 2'($urandom));
    check(oidx == n - DEPTH + 1, "R4/R5 output count", oidx, n - DEPTH + 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run(100, 0, 0, 0);
    run(100, 1, 0, 0);
    run(400, 2, 0, 1);
    run(900, 2, 45, 1);
    run(600, 3, 0, 0);
    run(300, 2, 50, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule